// File: doc/BRIEF.md
# Bus Controller Idle Clock Gating

This block saves power in a bus control unit by switching off the unit's internal clock whenever the bus has nothing to do. Request detection and the gating state machine run on the free-running clock. The controller logic downstream runs on the gated clock output. When any master raises its request line, the block turns the gated clock back on. It waits a fixed settling interval and only then grants permission to arbitrate. After the last transfer finishes and no master is asking for the bus, the block passes through a short drain step and gates the clock again.

A single configuration bit turns the feature on. It resets to 0, so after reset the gated clock runs all the time. This keeps the clock running in both idle and active bus phases, which is useful when debugging. Clearing the bit at any time, including while the clock is gated, forces the clock back on. The enable that drives the clock AND gate is captured on the falling edge of the free clock, so the gated clock never carries a partial pulse. All pins are plain control and status signals. There is no data stream, and so there is no valid/ready handshake.

Top module: `bus_idle_clkgate`

## Requirements
- R1: After reset, the power-save bit `pse_o` is 0, `state_o` is ACTIVE, and `clk_en_o` is 1.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the power-save bit, and `pse_o` shows it from the next cycle.
- R3: While the power-save bit is 0, `state_o` goes to or stays in ACTIVE, and `clk_en_o` stays at 1.
- R4: `state_o` is encoded as GATED=0, WAKE=1, ACTIVE=2 and DRAIN=3. With the power-save bit set, ACTIVE moves to DRAIN on an edge where no registered request is pending and `bus_busy` is low. DRAIN moves to GATED when no request is pending. In GATED, the clock enable drops one cycle later.
- R5: Each `mst_req` bit is registered once. In GATED, a pending registered request moves the block to WAKE. WAKE lasts exactly WAKE_CYCLES cycles (default 2) and is followed by ACTIVE.
- R6: `arb_go_o` is high only when the state is ACTIVE and a registered request is pending. It is never high in GATED, WAKE or DRAIN.
- R7: A registered request that is pending while in DRAIN sends the block back to ACTIVE. The clock enable does not drop.
- R8: Clearing the power-save bit while in GATED moves the block to ACTIVE on the next edge, and the clock enable returns to 1.
- R9: `clk_en_o` changes only on falling edges of `clk`. While `clk` is high, `gclk_o` equals `clk_en_o`, and while `clk` is low it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the power-save bit |
| cfg_wdata | input | 1 | Value written to the power-save bit |
| mst_req | input | N_MASTERS | Bus request, one bit per master |
| bus_busy | input | 1 | A transfer is in progress |
| pse_o | output | 1 | Current power-save bit |
| clk_en_o | output | 1 | Enable driving the clock gate, changes on falling edges |
| gclk_o | output | 1 | Gated controller clock |
| arb_go_o | output | 1 | Arbitration may proceed this cycle |
| state_o | output | 2 | Gating state (GATED=0, WAKE=1, ACTIVE=2, DRAIN=3) |

## Verification
Directed sequences cover each kind of transition in turn:
- With power saving off, idle cycles show that the clock is never gated.
- With it on, idle cycles bring the block to GATED, which shows the drain path and the late drop of the enable.
- A single request pulse measures the length of WAKE and the point where arbitration opens.
- A request that lands exactly in DRAIN separates a return to ACTIVE from a wrong trip through GATED.
- Clearing the bit while gated tests the forced wake-up.

After these, sparse random requests, busy phases and occasional writes to the bit are compared every cycle against a reference model of the requirements. These random runs cover state changes that occur on the same edge.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [1:0] {
    ST_GATED  = 2'd0,
    ST_WAKE   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_DRAIN  = 2'd3
  } gate_st_e;
endpackage

// File: rtl/bcg_cfg_bit.sv
module bcg_cfg_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wdata,
  output logic pse
);
  // Power-save enable, cleared by reset so the clock starts free-running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pse <= 1'b0;
    else if (we) pse <= wdata;
  end
endmodule

// File: rtl/bcg_req_sync.sv
module bcg_req_sync #(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_i,
  output logic                 req_any_o
);
  logic [N_MASTERS-1:0] req_q;

  // Each request line is captured on the ungated clock, so nothing is missed while gated.
  for (genvar g = 0; g < N_MASTERS; g++) begin : g_req
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[g] <= 1'b0;
      else        req_q[g] <= req_i[g];
    end
  end

  assign req_any_o = |req_q;
endmodule

// File: rtl/bcg_fsm.sv
module bcg_fsm
  import bcg_pkg::*;
#(
  parameter int WAKE_CYCLES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pse,
  input  logic     req_any,
  input  logic     bus_busy,
  output gate_st_e state_o,
  output logic     arb_go_o,
  output logic     en_req_o
);
  localparam int CW = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

  gate_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!pse) begin
      st_d = ST_ACTIVE;
    end else begin
      unique case (st_q)
        ST_GATED: if (req_any) begin
          st_d  = ST_WAKE;
          cnt_d = '0;
        end
        ST_WAKE: begin
          if (cnt_q == WAKE_LAST) st_d = ST_ACTIVE;
          else                    cnt_d = cnt_q + 1'b1;
        end
        ST_ACTIVE: if (!req_any && !bus_busy) st_d = ST_DRAIN;
        ST_DRAIN: st_d = req_any ? ST_ACTIVE : ST_GATED;
        default: st_d = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ACTIVE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o  = st_q;
  assign arb_go_o = (st_q == ST_ACTIVE) && req_any;
  assign en_req_o = !pse || (st_q != ST_GATED);

  AST_WAKE_EXITS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAKE) |=> (st_q == ST_WAKE || st_q == ST_ACTIVE)); // R5
  AST_DRAIN_REQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && req_any) |=> (st_q == ST_ACTIVE)); // R7
  AST_FORCE_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GATED && !pse) |=> (st_q == ST_ACTIVE)); // R8
endmodule

// File: rtl/bcg_gate.sv
module bcg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  output logic clk_en_o,
  output logic gclk_o
);
  logic en_n;

  // Enable is captured while clk is low, so the AND below never chops a high phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_n <= 1'b1;
    else        en_n <= en_req;
  end

  assign clk_en_o = en_n;
  assign gclk_o   = clk & en_n;
endmodule

// File: rtl/bus_idle_clkgate.sv
module bus_idle_clkgate
  import bcg_pkg::*;
#(
  parameter int N_MASTERS   = 4,
  parameter int WAKE_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_wdata,
  input  logic [N_MASTERS-1:0] mst_req,
  input  logic                 bus_busy,
  output logic                 pse_o,
  output logic                 clk_en_o,
  output logic                 gclk_o,
  output logic                 arb_go_o,
  output logic [1:0]           state_o
);
  logic     pse, req_any, en_req;
  gate_st_e st;

  bcg_cfg_bit u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .pse(pse));

  bcg_req_sync #(.N_MASTERS(N_MASTERS)) u_req (
    .clk(clk), .rst_n(rst_n), .req_i(mst_req), .req_any_o(req_any));

  bcg_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pse(pse), .req_any(req_any), .bus_busy(bus_busy),
    .state_o(st), .arb_go_o(arb_go_o), .en_req_o(en_req));

  bcg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .clk_en_o(clk_en_o), .gclk_o(gclk_o));

  assign pse_o   = pse;
  assign state_o = st;

  AST_NOPSE_CLK_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !pse |-> clk_en_o); // R3
  AST_ARB_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    arb_go_o |-> clk_en_o); // R6
endmodule

// File: tb/bus_idle_clkgate_tb_top.sv
`timescale 1ns/1ps
module bus_idle_clkgate_tb_top;
  localparam int NM = 4;
  localparam int WK = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_wdata = 1'b0, bus_busy = 1'b0;
  logic [NM-1:0] mst_req = '0;
  logic pse_o, clk_en_o, gclk_o, arb_go_o;
  logic [1:0] state_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // reference model state
  int m_st, m_cnt;
  bit m_rq, m_pse, m_en;

  always #2.5 clk = ~clk;

  bus_idle_clkgate #(.N_MASTERS(NM), .WAKE_CYCLES(WK)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mst_req(mst_req), .bus_busy(bus_busy), .pse_o(pse_o), .clk_en_o(clk_en_o),
    .gclk_o(gclk_o), .arb_go_o(arb_go_o), .state_o(state_o));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int next_state(int st, int cnt, bit pse, bit rq, bit busy);
    if (!pse) return 2;
    case (st)
      0: return rq ? 1 : 0;
      1: return (cnt == WK - 1) ? 2 : 1;
      2: return (!rq && !busy) ? 3 : 2;
      default: return rq ? 2 : 0;
    endcase
  endfunction

  task automatic model_step();
    int ns;
    ns = next_state(m_st, m_cnt, m_pse, m_rq, bus_busy);
    if (m_st == 0 && ns == 1) m_cnt = 0;
    else if (m_st == 1 && ns == 1) m_cnt = m_cnt + 1;
    m_en = !m_pse || (m_st != 0);
    m_st = ns;
    m_rq = |mst_req;
    if (cfg_we) m_pse = cfg_wdata;
  endtask

  // One clock: model update at the edge, compare 1 ns later (clk high), return at falling edge.
  task automatic cycle(input string tag);
    @(posedge clk);
    model_step();
    #1;
    chk({tag, " R4 state"}, state_o, m_st);
    chk({tag, " R6 arb_go"}, arb_go_o, int'(m_st == 2 && m_rq));
    chk({tag, " R9 clk_en"}, clk_en_o, m_en);
    chk({tag, " R9 gclk"}, gclk_o, m_en);
    chk({tag, " R2 pse"}, pse_o, m_pse);
    @(negedge clk);
    #0.1;
    chk({tag, " R9 gclk low"}, gclk_o, 0);
  endtask

  task automatic write_pse(input bit v);
    cfg_we = 1'b1; cfg_wdata = v;
    cycle("R2 write");
    cfg_we = 1'b0;
  endtask

  initial begin : main
    int wake_seen;
    process_init: begin
      m_st = 2; m_cnt = 0; m_rq = 0; m_pse = 0; m_en = 1;
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset state", state_o, 2);
    chk("R1 reset pse", pse_o, 0);
    chk("R1 reset clk_en", clk_en_o, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: power save off, idle bus never gates
    for (int i = 0; i < 6; i++) cycle("R3 idle");
    chk("R3 still active", state_o, 2);
    chk("R3 clock on", clk_en_o, 1);

    // R4: enable power save, idle bus drains and gates
    write_pse(1'b1);
    for (int i = 0; i < 5; i++) cycle("R4 drain");
    chk("R4 gated state", state_o, 0);
    chk("R4 gated clk_en", clk_en_o, 0);

    // R5: one request pulse, count WAKE cycles
    mst_req = 4'b0100;
    cycle("R5 req");
    mst_req = '0;
    wake_seen = 0;
    for (int i = 0; i < 6; i++) begin
      cycle("R5 wake");
      if (state_o == 2'd1) wake_seen++;
    end
    chk("R5 wake length", wake_seen, WK);

    // R7: request landing in DRAIN returns to ACTIVE without gating
    mst_req = 4'b0001; bus_busy = 1'b1;
    for (int i = 0; i < 3; i++) cycle("R7 busy");
    mst_req = '0;
    for (int i = 0; i < 2; i++) cycle("R7 busy");
    bus_busy = 1'b0; mst_req = 4'b1000;
    cycle("R7 enter drain");
    chk("R7 in drain", state_o, 3);
    mst_req = '0;
    cycle("R7 back");
    chk("R7 active again", state_o, 2);
    cycle("R7 hold");
    chk("R7 no gating", clk_en_o, 1);

    // R8: clear power save while gated
    for (int i = 0; i < 5; i++) cycle("R8 settle");
    chk("R8 gated first", state_o, 0);
    write_pse(1'b0);
    cycle("R8 wake");
    chk("R8 forced active", state_o, 2);
    cycle("R8 clock");
    chk("R8 clock on", clk_en_o, 1);

    // random mix checked against the model every cycle
    void'($urandom(32'h5EED_1234));
    write_pse(1'b1);
    for (int i = 0; i < 3000; i++) begin
      for (int b = 0; b < NM; b++) mst_req[b] = ($urandom_range(0, 11) == 0);
      bus_busy = ($urandom_range(0, 3) == 0);
      cfg_we = ($urandom_range(0, 39) == 0);
      cfg_wdata = ($urandom_range(0, 3) != 0);
      cycle("RND");
    end
    cfg_we = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule